// File: doc/BRIEF.md
# Frame Motion Statistics Engine

This block judges whether a scene has changed between two frames. It receives two
downscaled 8-bit images in lockstep, one pixel per valid cycle in raster order: the
current frame and the frame before it. For every pixel position it forms a windowed
sum of absolute differences (SAD) over a kernel whose shape is chosen by a mode input.
It also derives a gradient strength ("edge") from each frame. The SAD is reduced by a
fixed coring value, and compared against a threshold that grows with local edge
strength. The result is one motion bit per pixel. These bits leave the block in raster
order, one for each pixel of the frame.

Inside a rectangular statistics region, given in inclusive downscaled coordinates, the
block accumulates three totals: cored SAD, motion-bit count and edge. When a frame has
been fully processed it raises a one-cycle completion pulse. In the same cycle it
raises an interrupt pulse if either the SAD total or the motion-bit count is above its
threshold. The totals stay on the outputs until the next frame begins, and they
saturate rather than wrap. Internally, four rows of each stream are held so that a
3-row kernel can be formed. A row is swept one row after it arrives. The source must
wait for the completion pulse before it starts the next frame.

Top module: `md_sad_motion`

## Requirements
- R1: After synchronous reset all totals read 0, and `mot_vld_o`, `mot_o`, `done_o` and `irq_o` are low.
- R2: `sad_mode` selects the SAD kernel as rows by columns, centred on the pixel: 0 gives no SAD (always 0), 1 gives 1x7, 2 gives 3x3, 3 gives 3x5, and every value from 4 to 7 gives 3x7.
- R3: Each in-region pixel adds max(SAD − `coring`, 0) to `sad_sum_o`.
- R4: A pixel's motion bit is 1 exactly when its uncored SAD is greater than floor(E·`edge_ratio`/16) + `coring`, where E is the combined edge of R5.
- R5: A frame's edge at a pixel is |p(x+1,y) − p(x−1,y)| + |p(x,y+1) − p(x,y−1)|. When `edge_avg` is 0, E is the smaller of the current and previous edge. When it is 1, E is floor of their mean. Every in-region pixel adds E to `edge_sum_o`.
- R6: A kernel or edge sample that falls outside the image takes the value of the nearest pixel inside it. Rows and columns are clamped independently.
- R7: Only pixels with `win_x0` ≤ x ≤ `win_x1` and `win_y0` ≤ y ≤ `win_y1` contribute to the three totals. Bounds beyond the image are allowed.
- R8: A `frm_start` pulse clears all three totals; they read 0 in the following cycle.
- R9: `done_o` is a one-cycle pulse after the last pixel of a frame. `irq_o` pulses in the same cycle if `sad_sum_o` > `sad_thr` or `mot_sum_o` > `mot_thr`. A total equal to its threshold does not count.
- R10: One motion bit is emitted per pixel, with `mot_vld_o` high, in raster order. This holds whether the input pixels arrive back to back or with idle gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Begins a frame and clears the totals |
| pix_vld | input | 1 | A pixel pair is present on `cur_pix`/`prv_pix` |
| cur_pix | input | 8 | Current-frame sample |
| prv_pix | input | 8 | Previous-frame sample |
| img_w | input | CW (10) | Image width in pixels, 1 to MAX_W |
| img_h | input | CW (10) | Image height in rows, at least 1 |
| sad_mode | input | 3 | SAD kernel shape |
| edge_avg | input | 1 | Edge combine: 0 minimum, 1 mean |
| coring | input | 8 | Fixed coring value |
| edge_ratio | input | 6 | Edge gain, 16 = unity |
| win_x0 | input | CW (10) | Region first column |
| win_x1 | input | CW (10) | Region last column |
| win_y0 | input | CW (10) | Region first row |
| win_y1 | input | CW (10) | Region last row |
| sad_thr | input | 24 | SAD total threshold |
| mot_thr | input | 16 | Motion-count threshold |
| mot_vld_o | output | 1 | A motion bit is valid |
| mot_o | output | 1 | Per-pixel motion bit |
| sad_sum_o | output | 28 | Cored SAD total |
| mot_sum_o | output | 20 | Motion-bit count |
| edge_sum_o | output | 28 | Edge total |
| done_o | output | 1 | Frame-complete pulse |
| irq_o | output | 1 | Motion interrupt pulse |

## Verification
Some properties are checked on every cycle. A motion bit only appears with its valid
strobe, and no pixel flags motion unless its SAD exceeds the coring value. The totals
never fall between frame starts. The completion pulse lasts one cycle, and the
interrupt appears only with that pulse. A quiet completion has both totals at or below
their thresholds. Other behaviours need the scenarios to show them: the per-pixel bit
for each kernel shape, the two edge-combine modes, replication at the borders, the
region limits, and the strict threshold comparison at equality.

// File: rtl/md_pkg.sv
package md_pkg;
    localparam int PIX_W  = 8;
    localparam int WROWS  = 3;
    localparam int WCOLS  = 7;
    localparam int SAD_W  = 13;
    localparam int EDGE_W = 9;

    typedef logic [PIX_W-1:0] pix_t;
    // [row][col]: row 0 is the line above, col 0 is three columns to the left
    typedef pix_t [WROWS-1:0][WCOLS-1:0] win_t;

    typedef enum logic [2:0] {
        SHP_NONE,
        SHP_1X7,
        SHP_3X3,
        SHP_3X5,
        SHP_3X7
    } shape_e;

    typedef struct packed {
        logic [SAD_W-1:0]  sad_raw;
        logic [SAD_W-1:0]  sad_cored;
        logic [EDGE_W-1:0] edge_v;
        logic              mot;
    } pix_res_t;

    function automatic shape_e decode_shape(input logic [2:0] code);
        case (code)
            3'd0:    return SHP_NONE;
            3'd1:    return SHP_1X7;
            3'd2:    return SHP_3X3;
            3'd3:    return SHP_3X5;
            default: return SHP_3X7;
        endcase
    endfunction

    function automatic logic tap_used(input shape_e s, input int r, input int c);
        case (s)
            SHP_NONE: return 1'b0;
            SHP_1X7:  return (r == 1);
            SHP_3X3:  return (c >= 2) && (c <= 4);
            SHP_3X5:  return (c >= 1) && (c <= 5);
            default:  return 1'b1;
        endcase
    endfunction

    function automatic pix_t abs_diff(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/md_row_store.sv
module md_row_store
    import md_pkg::*;
#(
    parameter int MAX_W = 64,
    parameter int CW    = 10
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [1:0]      wr_slot,
    input  logic [CW-1:0]   wr_col,
    input  pix_t            wr_data,
    input  logic [2:0][1:0] rd_slot,
    input  logic [CW-1:0]   rd_col,
    input  logic [CW-1:0]   img_w,
    output win_t            win
);
    localparam int AW     = $clog2(MAX_W);
    localparam int NSLOT  = 4;
    localparam int HALF_C = WCOLS / 2;

    pix_t mem [NSLOT][MAX_W];

    function automatic logic [AW-1:0] col_at(input logic [CW-1:0] base, input int off,
                                             input logic [CW-1:0] w);
        int v;
        v = int'(base) + off;
        if (v > int'(w) - 1) v = int'(w) - 1;
        if (v < 0) v = 0;
        return AW'(v);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot][wr_col[AW-1:0]] <= wr_data;
    end

    always_comb begin
        for (int r = 0; r < WROWS; r++) begin
            for (int c = 0; c < WCOLS; c++) begin
                win[r][c] = mem[rd_slot[r]][col_at(rd_col, c - HALF_C, img_w)];
            end
        end
    end
endmodule

// File: rtl/md_pixel_core.sv
module md_pixel_core
    import md_pkg::*;
(
    input  win_t       cur_win,
    input  win_t       prv_win,
    input  logic [2:0] sad_mode,
    input  logic       edge_avg,
    input  logic [7:0] coring,
    input  logic [5:0] edge_ratio,
    output pix_res_t   res
);
    localparam int SCL_W = EDGE_W + 6;
    localparam int THR_W = 16;

    shape_e            shape;
    logic [SAD_W-1:0]  sad_acc;
    logic [EDGE_W-1:0] edg_cur, edg_prv, edg_sel;
    logic [EDGE_W:0]   edg_pair;
    logic [SCL_W-1:0]  edg_scaled;
    logic [THR_W-1:0]  dyn_thr;

    function automatic logic [EDGE_W-1:0] grad_at_centre(input win_t w);
        return EDGE_W'(abs_diff(w[1][4], w[1][2])) + EDGE_W'(abs_diff(w[2][3], w[0][3]));
    endfunction

    always_comb begin
        shape   = decode_shape(sad_mode);
        sad_acc = '0;
        for (int r = 0; r < WROWS; r++) begin
            for (int c = 0; c < WCOLS; c++) begin
                if (tap_used(shape, r, c))
                    sad_acc = sad_acc + SAD_W'(abs_diff(cur_win[r][c], prv_win[r][c]));
            end
        end
        edg_cur    = grad_at_centre(cur_win);
        edg_prv    = grad_at_centre(prv_win);
        edg_pair   = {1'b0, edg_cur} + {1'b0, edg_prv};
        edg_sel    = edge_avg ? edg_pair[EDGE_W:1] : ((edg_cur < edg_prv) ? edg_cur : edg_prv);
        edg_scaled = SCL_W'(edg_sel) * SCL_W'(edge_ratio);
        dyn_thr    = THR_W'(edg_scaled >> 4) + THR_W'(coring);

        res.sad_raw   = sad_acc;
        res.sad_cored = (sad_acc > SAD_W'(coring)) ? (sad_acc - SAD_W'(coring)) : '0;
        res.edge_v    = edg_sel;
        res.mot       = (THR_W'(sad_acc) > dyn_thr);
    end
endmodule

// File: rtl/md_frame_stats.sv
module md_frame_stats
    import md_pkg::*;
#(
    parameter int SUM_W  = 28,
    parameter int CNT_W  = 20,
    parameter int STHR_W = 24,
    parameter int MTHR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc_en,
    input  logic              in_win,
    input  logic              last_px,
    input  pix_res_t          px,
    input  logic [STHR_W-1:0] sad_thr,
    input  logic [MTHR_W-1:0] mot_thr,
    output logic [SUM_W-1:0]  sad_sum,
    output logic [CNT_W-1:0]  mot_sum,
    output logic [SUM_W-1:0]  edg_sum,
    output logic              done,
    output logic              irq
);
    localparam int SW1 = SUM_W + 1;
    localparam int CW1 = CNT_W + 1;

    logic           take, last_q;
    logic [SUM_W:0] sad_nx, edg_nx;
    logic [CNT_W:0] mot_nx;

    always_comb begin
        take   = acc_en && in_win;
        sad_nx = {1'b0, sad_sum} + SW1'(px.sad_cored);
        edg_nx = {1'b0, edg_sum} + SW1'(px.edge_v);
        mot_nx = {1'b0, mot_sum} + CW1'(px.mot);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sad_sum <= '0;
            mot_sum <= '0;
            edg_sum <= '0;
            last_q  <= 1'b0;
            done    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (take) begin
                sad_sum <= sad_nx[SUM_W] ? '1 : sad_nx[SUM_W-1:0];
                edg_sum <= edg_nx[SUM_W] ? '1 : edg_nx[SUM_W-1:0];
                mot_sum <= mot_nx[CNT_W] ? '1 : mot_nx[CNT_W-1:0];
            end
            last_q <= acc_en && last_px;
            done   <= last_q;
            irq    <= last_q && ((sad_sum > SUM_W'(sad_thr)) || (mot_sum > CNT_W'(mot_thr)));
        end
    end

    AST_SAD_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> sad_sum >= $past(sad_sum)); // R3
    AST_MOT_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> mot_sum >= $past(mot_sum)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> done); // R9
    AST_QUIET_BELOW_THR: assert property (@(posedge clk) disable iff (rst)
        (done && !irq) |-> (sad_sum <= SUM_W'(sad_thr)) && (mot_sum <= CNT_W'(mot_thr))); // R9
endmodule

// File: rtl/md_sad_motion.sv
module md_sad_motion
    import md_pkg::*;
#(
    parameter int MAX_W  = 64,
    parameter int CW     = 10,
    parameter int SUM_W  = 28,
    parameter int CNT_W  = 20,
    parameter int STHR_W = 24,
    parameter int MTHR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              pix_vld,
    input  logic [7:0]        cur_pix,
    input  logic [7:0]        prv_pix,
    input  logic [CW-1:0]     img_w,
    input  logic [CW-1:0]     img_h,
    input  logic [2:0]        sad_mode,
    input  logic              edge_avg,
    input  logic [7:0]        coring,
    input  logic [5:0]        edge_ratio,
    input  logic [CW-1:0]     win_x0,
    input  logic [CW-1:0]     win_x1,
    input  logic [CW-1:0]     win_y0,
    input  logic [CW-1:0]     win_y1,
    input  logic [STHR_W-1:0] sad_thr,
    input  logic [MTHR_W-1:0] mot_thr,
    output logic              mot_vld_o,
    output logic              mot_o,
    output logic [SUM_W-1:0]  sad_sum_o,
    output logic [CNT_W-1:0]  mot_sum_o,
    output logic [SUM_W-1:0]  edge_sum_o,
    output logic              done_o,
    output logic              irq_o
);
    localparam int NSTREAM = 2;

    logic [CW-1:0]   in_x, rows_rcv, sw_row, sw_col, nxt_row, row_up, row_dn;
    logic            sw_act, frm_act, wr_ok, rdy_cur, rdy_nxt, last_px, in_win;
    logic [2:0][1:0] rd_slot;
    win_t            wins [NSTREAM];
    pix_res_t        px_res;

    function automatic logic [CW:0] rows_needed(input logic [CW-1:0] r, input logic [CW-1:0] h);
        logic [CW:0] want;
        want = {1'b0, r} + (CW+1)'(2);
        return (want > {1'b0, h}) ? {1'b0, h} : want;
    endfunction

    always_comb begin
        nxt_row = sw_row + 1'b1;
        rdy_cur = frm_act && (sw_row < img_h) &&
                  ({1'b0, rows_rcv} >= rows_needed(sw_row, img_h));
        rdy_nxt = frm_act && (nxt_row < img_h) &&
                  ({1'b0, rows_rcv} >= rows_needed(nxt_row, img_h));
        wr_ok   = pix_vld && frm_act && (rows_rcv < img_h);
        last_px = sw_act && (sw_row == img_h - 1'b1) && (sw_col == img_w - 1'b1);
        row_up  = (sw_row == '0) ? '0 : sw_row - 1'b1;
        row_dn  = ({1'b0, sw_row} + 1'b1 >= {1'b0, img_h}) ? img_h - 1'b1 : nxt_row;
        rd_slot[0] = row_up[1:0];
        rd_slot[1] = sw_row[1:0];
        rd_slot[2] = row_dn[1:0];
        in_win  = (sw_col >= win_x0) && (sw_col <= win_x1) &&
                  (sw_row >= win_y0) && (sw_row <= win_y1);
    end

    // input row counting and sweep sequencing
    always_ff @(posedge clk) begin
        if (rst || frm_start) begin
            in_x     <= '0;
            rows_rcv <= '0;
            sw_row   <= '0;
            sw_col   <= '0;
            sw_act   <= 1'b0;
            frm_act  <= !rst;
        end else begin
            if (wr_ok) begin
                if (in_x == img_w - 1'b1) begin
                    in_x     <= '0;
                    rows_rcv <= rows_rcv + 1'b1;
                end else begin
                    in_x <= in_x + 1'b1;
                end
            end
            if (!sw_act) begin
                if (rdy_cur) begin
                    sw_act <= 1'b1;
                    sw_col <= '0;
                end
            end else if (sw_col == img_w - 1'b1) begin
                sw_col <= '0;
                sw_row <= nxt_row;
                sw_act <= rdy_nxt;
                if (last_px) frm_act <= 1'b0;
            end else begin
                sw_col <= sw_col + 1'b1;
            end
        end
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_store
        md_row_store #(.MAX_W(MAX_W), .CW(CW)) i_store (
            .clk     (clk),
            .wr_en   (wr_ok),
            .wr_slot (rows_rcv[1:0]),
            .wr_col  (in_x),
            .wr_data ((s == 0) ? cur_pix : prv_pix),
            .rd_slot (rd_slot),
            .rd_col  (sw_col),
            .img_w   (img_w),
            .win     (wins[s])
        );
    end

    md_pixel_core i_core (
        .cur_win    (wins[0]),
        .prv_win    (wins[1]),
        .sad_mode   (sad_mode),
        .edge_avg   (edge_avg),
        .coring     (coring),
        .edge_ratio (edge_ratio),
        .res        (px_res)
    );

    md_frame_stats #(
        .SUM_W(SUM_W), .CNT_W(CNT_W), .STHR_W(STHR_W), .MTHR_W(MTHR_W)
    ) i_stats (
        .clk     (clk),
        .rst     (rst),
        .clr     (frm_start),
        .acc_en  (sw_act),
        .in_win  (in_win),
        .last_px (last_px),
        .px      (px_res),
        .sad_thr (sad_thr),
        .mot_thr (mot_thr),
        .sad_sum (sad_sum_o),
        .mot_sum (mot_sum_o),
        .edg_sum (edge_sum_o),
        .done    (done_o),
        .irq     (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mot_vld_o <= 1'b0;
            mot_o     <= 1'b0;
        end else begin
            mot_vld_o <= sw_act;
            mot_o     <= sw_act && px_res.mot;
        end
    end

    AST_MOT_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        mot_o |-> mot_vld_o); // R10
    AST_MOT_ABOVE_CORING: assert property (@(posedge clk) disable iff (rst)
        (sw_act && px_res.mot) |-> (px_res.sad_raw > SAD_W'(coring))); // R4
endmodule

// File: tb/test_md_sad_motion.sv
`timescale 1ns/1ps
module test_md_sad_motion;
    localparam int MAXD = 16;

    typedef struct {
        longint sad;
        longint mot;
        longint edg;
        bit     irq;
    } frm_exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_start = 1'b0;
    logic        pix_vld = 1'b0;
    logic [7:0]  cur_pix = '0, prv_pix = '0;
    logic [9:0]  img_w = 10'd8, img_h = 10'd6;
    logic [2:0]  sad_mode = 3'd2;
    logic        edge_avg = 1'b0;
    logic [7:0]  coring = 8'd6;
    logic [5:0]  edge_ratio = 6'd4;
    logic [9:0]  win_x0 = '0, win_x1 = 10'd1023, win_y0 = '0, win_y1 = 10'd1023;
    logic [23:0] sad_thr = '1;
    logic [15:0] mot_thr = '1;
    logic        mot_vld_o, mot_o, done_o, irq_o;
    logic [27:0] sad_sum_o, edge_sum_o;
    logic [19:0] mot_sum_o;

    int n_checks = 0, n_err = 0, done_cnt = 0;
    bit finished = 0;
    string cur_req = "R3";
    int unsigned seed = 32'h1234_5678;
    int cur_a [MAXD][MAXD];
    int prv_a [MAXD][MAXD];
    bit exp_bits [$];
    bit frame_bits [$];
    frm_exp_t frm_q [$];
    longint e_sad, e_mot, e_edg;
    bit mon_b;
    frm_exp_t mon_f;

    md_sad_motion i_md_sad_motion (
        .clk(clk), .rst(rst), .frm_start(frm_start), .pix_vld(pix_vld),
        .cur_pix(cur_pix), .prv_pix(prv_pix), .img_w(img_w), .img_h(img_h),
        .sad_mode(sad_mode), .edge_avg(edge_avg), .coring(coring), .edge_ratio(edge_ratio),
        .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
        .sad_thr(sad_thr), .mot_thr(mot_thr), .mot_vld_o(mot_vld_o), .mot_o(mot_o),
        .sad_sum_o(sad_sum_o), .mot_sum_o(mot_sum_o), .edge_sum_o(edge_sum_o),
        .done_o(done_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFF);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int pv(input bit from_prv, input int y, input int x);
        int yy, xx;
        yy = (y < 0) ? 0 : ((y >= int'(img_h)) ? int'(img_h) - 1 : y);
        xx = (x < 0) ? 0 : ((x >= int'(img_w)) ? int'(img_w) - 1 : x);
        return from_prv ? prv_a[yy][xx] : cur_a[yy][xx];
    endfunction

    function automatic int sad_model(input int y, input int x);
        int s = 0;
        bit use_t;
        for (int dy = -1; dy <= 1; dy++) begin
            for (int dx = -3; dx <= 3; dx++) begin
                case (sad_mode)
                    3'd0:    use_t = 0;
                    3'd1:    use_t = (dy == 0);
                    3'd2:    use_t = (iabs(dx) <= 1);
                    3'd3:    use_t = (iabs(dx) <= 2);
                    default: use_t = 1;
                endcase
                if (use_t) s += iabs(pv(0, y + dy, x + dx) - pv(1, y + dy, x + dx));
            end
        end
        return s;
    endfunction

    function automatic int grad_model(input bit from_prv, input int y, input int x);
        return iabs(pv(from_prv, y, x + 1) - pv(from_prv, y, x - 1)) +
               iabs(pv(from_prv, y + 1, x) - pv(from_prv, y - 1, x));
    endfunction

    // kind 0: identical frames, 1: sparse small changes, 2: unrelated frames
    task automatic gen_frame(input int kind);
        for (int y = 0; y < MAXD; y++) begin
            for (int x = 0; x < MAXD; x++) begin
                cur_a[y][x] = rnd8();
                prv_a[y][x] = cur_a[y][x];
                if (kind == 2) prv_a[y][x] = rnd8();
                else if (kind == 1 && (rnd8() % 4) == 0)
                    prv_a[y][x] = (cur_a[y][x] + (rnd8() % 24)) % 256;
            end
        end
    endtask

    task automatic model_frame();
        int s, ec, ep, eg, dyn;
        bit m;
        e_sad = 0; e_mot = 0; e_edg = 0;
        frame_bits.delete();
        for (int y = 0; y < int'(img_h); y++) begin
            for (int x = 0; x < int'(img_w); x++) begin
                s   = sad_model(y, x);
                ec  = grad_model(0, y, x);
                ep  = grad_model(1, y, x);
                eg  = edge_avg ? (ec + ep) / 2 : ((ec < ep) ? ec : ep);
                dyn = (eg * int'(edge_ratio)) / 16 + int'(coring);
                m   = (s > dyn);
                frame_bits.push_back(m);
                if (x >= int'(win_x0) && x <= int'(win_x1) && y >= int'(win_y0) && y <= int'(win_y1)) begin
                    e_sad += (s > int'(coring)) ? s - int'(coring) : 0;
                    e_mot += m;
                    e_edg += eg;
                end
            end
        end
    endtask

    task automatic run_frame(input bit gaps);
        frm_exp_t f;
        int start_cnt;
        model_frame();
        foreach (frame_bits[i]) exp_bits.push_back(frame_bits[i]);
        f.sad = e_sad; f.mot = e_mot; f.edg = e_edg;
        f.irq = (e_sad > longint'(sad_thr)) || (e_mot > longint'(mot_thr));
        frm_q.push_back(f);
        start_cnt = done_cnt;
        @(negedge clk) frm_start = 1'b1;
        @(negedge clk) frm_start = 1'b0;
        check(sad_sum_o == 0 && mot_sum_o == 0 && edge_sum_o == 0, "R8",
              longint'(sad_sum_o) + mot_sum_o + edge_sum_o, 0);
        for (int y = 0; y < int'(img_h); y++) begin
            for (int x = 0; x < int'(img_w); x++) begin
                pix_vld = 1'b1;
                cur_pix = 8'(cur_a[y][x]);
                prv_pix = 8'(prv_a[y][x]);
                @(negedge clk);
                if (gaps && (x % 3 == 1)) begin
                    pix_vld = 1'b0;
                    repeat (2) @(negedge clk);
                end
            end
        end
        pix_vld = 1'b0;
        while (done_cnt == start_cnt) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mot_vld_o) begin
                if (exp_bits.size() == 0) begin
                    check(0, "R10", 1, 0);
                end else begin
                    mon_b = exp_bits.pop_front();
                    check(mot_o == mon_b, "R4/R10", mot_o, mon_b);
                end
            end
            if (done_o) begin
                done_cnt++;
                if (frm_q.size() == 0) begin
                    check(0, "R9", 1, 0);
                end else begin
                    mon_f = frm_q.pop_front();
                    check(sad_sum_o == mon_f.sad, cur_req, sad_sum_o, mon_f.sad);
                    check(mot_sum_o == mon_f.mot, cur_req, mot_sum_o, mon_f.mot);
                    check(edge_sum_o == mon_f.edg, cur_req, edge_sum_o, mon_f.edg);
                    check(irq_o == mon_f.irq, "R9", irq_o, mon_f.irq);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(sad_sum_o == 0 && mot_sum_o == 0 && edge_sum_o == 0, "R1",
              longint'(sad_sum_o) + mot_sum_o + edge_sum_o, 0);
        check(!mot_vld_o && !mot_o && !done_o && !irq_o, "R1",
              {mot_vld_o, mot_o, done_o, irq_o}, 0);

        // R3: identical frames give no SAD, edges still counted
        cur_req = "R3";
        gen_frame(0); run_frame(0);

        // R2: every kernel shape, including a code above 3
        cur_req = "R2";
        gen_frame(1);
        for (int m = 0; m < 8; m++) begin
            sad_mode = 3'(m);
            run_frame(0);
        end

        // R5: edge combine by mean and by minimum
        cur_req = "R5";
        sad_mode = 3'd2; coring = 8'd4; edge_ratio = 6'd16;
        gen_frame(1);
        edge_avg = 1'b1; run_frame(0);
        edge_avg = 1'b0; run_frame(0);

        // R6: tiny frames where most taps are replicated
        cur_req = "R6";
        edge_ratio = 6'd4; coring = 8'd6;
        img_w = 10'd3; img_h = 10'd2; sad_mode = 3'd7;
        gen_frame(2); run_frame(0);
        img_w = 10'd2; img_h = 10'd1; sad_mode = 3'd3;
        run_frame(0);

        // R7: statistics region inside the image
        cur_req = "R7";
        img_w = 10'd10; img_h = 10'd7; sad_mode = 3'd2;
        win_x0 = 10'd2; win_x1 = 10'd5; win_y0 = 10'd1; win_y1 = 10'd3;
        gen_frame(2); run_frame(0);
        win_x0 = '0; win_x1 = 10'd1023; win_y0 = '0; win_y1 = 10'd1023;

        // R9: strict comparison against each threshold
        cur_req = "R9";
        coring = 8'd20;
        gen_frame(2);
        model_frame();
        sad_thr = 24'(e_sad);     mot_thr = '1; run_frame(0);
        sad_thr = 24'(e_sad - 1);               run_frame(0);
        sad_thr = '1; mot_thr = 16'(e_mot);     run_frame(0);
        mot_thr = 16'(e_mot - 1);               run_frame(0);
        mot_thr = '1;

        // R10: larger frame with idle gaps between input pixels
        cur_req = "R10";
        coring = 8'd6; img_w = 10'd16; img_h = 10'd16;
        gen_frame(1); run_frame(1);

        // R3: coring at its maximum
        cur_req = "R3";
        coring = 8'd255; sad_mode = 3'd4;
        gen_frame(2); run_frame(0);

        check(exp_bits.size() == 0, "R10", exp_bits.size(), 0);
        check(frm_q.size() == 0, "R9", frm_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule